// File: doc/BRIEF.md
# Sixteen-Bit Execution Unit with Overflow Word

This block is the arithmetic and test stage of a small 16-bit processor core. Each cycle in which `valid_i` is high, it takes a 4-bit basic opcode and two already-fetched 16-bit operand values, `opa_i` (the destination's current value) and `opb_i` (the source value). In the same cycle it returns the value to write back, a write-enable, the skip request for the conditional tests, and the next value of a 16-bit overflow word. The overflow word is kept inside the block. Some opcodes load it from their own formula and others leave it as it is. It updates on the rising clock edge.

The overflow word is also visible to the rest of the core as an ordinary operand. It is read through `ovf_o`. It is written by raising `dst_ovf_i` when the instruction's destination is the overflow word, and in that case the written result takes the place of any formula value. Operand fetch, decode and memory are outside the block. Opcode 0 is reserved for the extended group and does nothing here.

Top module: `alu16_exec`

## Requirements
- R1: While reset is active, and in the first cycle after it, `ovf_o` reads 0.
- R2: Opcode 0x1 copies `opb_i` to `result_o` with `wr_en_o` high and leaves the overflow word unchanged.
- R3: Opcode 0x2 writes the 16-bit sum and sets the overflow word to 0x0001 on a carry out of bit 15, otherwise to 0x0000.
- R4: Opcode 0x3 writes `opa_i - opb_i` modulo 2^16 and sets the overflow word to 0xFFFF when `opb_i > opa_i` (unsigned), otherwise to 0x0000.
- R5: Opcode 0x4 writes the low 16 bits of the unsigned product and sets the overflow word to its high 16 bits.
- R6: Opcode 0x5 writes the unsigned quotient and sets the overflow word to bits 15:0 of `(opa_i * 65536) / opb_i`. A zero divisor writes 0 and sets the overflow word to 0.
- R7: Opcode 0x6 writes the unsigned remainder, or 0 for a zero divisor, and leaves the overflow word unchanged.
- R8: Opcode 0x7 shifts `opa_i` left by `opb_i`. The low 16 bits of the 32-bit shifted value are the result and the high 16 bits go to the overflow word. Opcode 0x8 shifts `opa_i * 65536` right by `opb_i`. Its high 16 bits are the result and its low 16 bits go to the overflow word. A shift of 32 or more gives 0 in both.
- R9: Opcodes 0x9, 0xA and 0xB write bitwise AND, OR and XOR and leave the overflow word unchanged.
- R10: Opcodes 0xC to 0xF never assert `wr_en_o` and never change the overflow word. They raise `skip_o` in these cases: 0xC when the operands differ, 0xD when they are equal, 0xE when `opa_i <= opb_i` (unsigned), 0xF when `opa_i & opb_i` is zero.
- R11: When `valid_i` is low, or the opcode is 0x0, `wr_en_o` and `skip_o` are low and the overflow word holds.
- R12: When `dst_ovf_i` is high and the instruction writes a result, the overflow word takes the result, overriding that opcode's own overflow formula.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the overflow word updates on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | An instruction is presented this cycle |
| opcode_i | input | 4 | Basic opcode |
| dst_ovf_i | input | 1 | The destination of this instruction is the overflow word |
| opa_i | input | 16 | Current value of the destination operand |
| opb_i | input | 16 | Source operand value |
| result_o | output | 16 | Value to write back to the destination |
| wr_en_o | output | 1 | Write back `result_o` this cycle |
| skip_o | output | 1 | The next instruction must be skipped |
| ovf_next_o | output | 16 | Overflow word value that takes effect at the next edge |
| ovf_o | output | 16 | Current overflow word |

## Verification
Each arithmetic opcode is driven with one operand pair that stays inside 16 bits and one that overflows, so a missing carry, borrow or high-half capture shows up as a wrong overflow word. Division and remainder are also tried with a zero divisor. Before the opcodes that must leave the overflow word alone, it is preloaded with a distinct pattern, so that a stray update cannot go unseen. The tests are given operands that are equal, ordered in each direction, straddling the unsigned sign bit, and with disjoint or overlapping bit masks, which separates each skip condition from its inverse and from a signed compare. Shifts use amounts of 0, 4, 20 and 40 to cover the carried-out bits and the flush to zero.

// File: rtl/alu16_pkg.sv
package alu16_pkg;
    typedef enum logic [3:0] {
        OP_EXT  = 4'h0,
        OP_SET  = 4'h1,
        OP_ADD  = 4'h2,
        OP_SUB  = 4'h3,
        OP_MUL  = 4'h4,
        OP_DIV  = 4'h5,
        OP_MOD  = 4'h6,
        OP_SHL  = 4'h7,
        OP_SHR  = 4'h8,
        OP_AND  = 4'h9,
        OP_BOR  = 4'hA,
        OP_XOR  = 4'hB,
        OP_TEQ  = 4'hC,
        OP_TNE  = 4'hD,
        OP_TGT  = 4'hE,
        OP_TBIT = 4'hF
    } op_e;
endpackage

// File: rtl/alu16_arith.sv
module alu16_arith
    import alu16_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [3:0]   op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] res,
    output logic         wr,
    output logic         ovf_upd,
    output logic [W-1:0] ovf_val
);
    localparam int W2 = 2 * W;

    logic [W:0]    sum;
    logic [W2-1:0] prod;
    logic [W2-1:0] quo_ext;
    logic [W-1:0]  quo;
    logic [W-1:0]  rem;
    logic [W2-1:0] shl_ext;
    logic [W2-1:0] shr_ext;
    logic          b_zero;

    always_comb begin
        b_zero  = (b == '0);
        sum     = {1'b0, a} + {1'b0, b};
        prod    = {{W{1'b0}}, a} * {{W{1'b0}}, b};
        quo     = b_zero ? '0 : a / b;
        rem     = b_zero ? '0 : a % b;
        quo_ext = b_zero ? '0 : {a, {W{1'b0}}} / {{W{1'b0}}, b};
        shl_ext = {{W{1'b0}}, a} << b;
        shr_ext = {a, {W{1'b0}}} >> b;

        res     = '0;
        wr      = 1'b1;
        ovf_upd = 1'b0;
        ovf_val = '0;
        unique case (op_e'(op))
            OP_SET: res = b;
            OP_ADD: begin
                res     = sum[W-1:0];
                ovf_upd = 1'b1;
                ovf_val = {{(W-1){1'b0}}, sum[W]};
            end
            OP_SUB: begin
                res     = a - b;
                ovf_upd = 1'b1;
                ovf_val = (b > a) ? '1 : '0;
            end
            OP_MUL: begin
                res     = prod[W-1:0];
                ovf_upd = 1'b1;
                ovf_val = prod[W2-1:W];
            end
            OP_DIV: begin
                res     = quo;
                ovf_upd = 1'b1;
                ovf_val = quo_ext[W-1:0];
            end
            OP_MOD: res = rem;
            OP_SHL: begin
                res     = shl_ext[W-1:0];
                ovf_upd = 1'b1;
                ovf_val = shl_ext[W2-1:W];
            end
            OP_SHR: begin
                res     = shr_ext[W2-1:W];
                ovf_upd = 1'b1;
                ovf_val = shr_ext[W-1:0];
            end
            OP_AND: res = a & b;
            OP_BOR: res = a | b;
            OP_XOR: res = a ^ b;
            default: wr = 1'b0;
        endcase
    end
endmodule

// File: rtl/alu16_test.sv
module alu16_test
    import alu16_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [3:0]   op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic         skip
);
    logic eq;
    logic gt;
    logic overlap;

    always_comb begin
        eq      = (a == b);
        gt      = (a > b);
        overlap = |(a & b);
        unique case (op_e'(op))
            OP_TEQ:  skip = !eq;
            OP_TNE:  skip = eq;
            OP_TGT:  skip = !gt;
            OP_TBIT: skip = !overlap;
            default: skip = 1'b0;
        endcase
    end
endmodule

// File: rtl/alu16_exec.sv
module alu16_exec
    import alu16_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         valid_i,
    input  logic [3:0]   opcode_i,
    input  logic         dst_ovf_i,
    input  logic [W-1:0] opa_i,
    input  logic [W-1:0] opb_i,
    output logic [W-1:0] result_o,
    output logic         wr_en_o,
    output logic         skip_o,
    output logic [W-1:0] ovf_next_o,
    output logic [W-1:0] ovf_o
);
    typedef struct packed {
        logic [W-1:0] ovf;
    } state_t;

    state_t st_d, st_q;

    logic [W-1:0] ar_res;
    logic         ar_wr;
    logic         ar_upd;
    logic [W-1:0] ar_ovf;
    logic         tst_skip;

    alu16_arith #(.W(W)) u_arith (
        .op      (opcode_i),
        .a       (opa_i),
        .b       (opb_i),
        .res     (ar_res),
        .wr      (ar_wr),
        .ovf_upd (ar_upd),
        .ovf_val (ar_ovf)
    );

    alu16_test #(.W(W)) u_test (
        .op   (opcode_i),
        .a    (opa_i),
        .b    (opb_i),
        .skip (tst_skip)
    );

    always_comb begin
        st_d     = st_q;
        wr_en_o  = valid_i && ar_wr;
        skip_o   = valid_i && tst_skip;
        result_o = ar_res;
        if (valid_i && ar_upd)
            st_d.ovf = ar_ovf;
        if (wr_en_o && dst_ovf_i)
            st_d.ovf = ar_res;
        ovf_next_o = st_d.ovf;
        ovf_o      = st_q.ovf;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    AST_TEST_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode_i[3:2] == 2'b11) |-> !wr_en_o); // R10
    AST_TEST_OVF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && opcode_i[3:2] == 2'b11) |=> $stable(ovf_o)); // R10
    AST_SKIP_ONLY_TEST: assert property (@(posedge clk) disable iff (!rst_n)
        skip_o |-> (valid_i && opcode_i[3:2] == 2'b11)); // R10
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid_i || opcode_i == 4'h0) |=> $stable(ovf_o)); // R11
    AST_ADD_CARRY_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && opcode_i == 4'h2 && !dst_ovf_i) |=> (ovf_o <= W'(1))); // R3
    AST_SUB_BORROW_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && opcode_i == 4'h3 && !dst_ovf_i) |=> (ovf_o == '0 || ovf_o == '1)); // R4
    AST_DIV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && opcode_i == 4'h5 && opb_i == '0) |-> (result_o == '0 && ovf_next_o == '0)); // R6
    AST_KEEP_OVF: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !dst_ovf_i && (opcode_i == 4'h1 || opcode_i == 4'h6 ||
         opcode_i == 4'h9 || opcode_i == 4'hA || opcode_i == 4'hB)) |=> $stable(ovf_o)); // R2
    AST_DST_OVF: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_o && dst_ovf_i) |=> (ovf_o == $past(result_o))); // R12
endmodule

// File: tb/alu16_exec_tb.sv
`timescale 1ns/1ps
module alu16_exec_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_i = 1'b0;
    logic [3:0]  opcode_i = 4'h0;
    logic        dst_ovf_i = 1'b0;
    logic [15:0] opa_i = '0;
    logic [15:0] opb_i = '0;
    logic [15:0] result_o;
    logic        wr_en_o;
    logic        skip_o;
    logic [15:0] ovf_next_o;
    logic [15:0] ovf_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    alu16_exec u_dut (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .opcode_i(opcode_i),
        .dst_ovf_i(dst_ovf_i), .opa_i(opa_i), .opb_i(opb_i),
        .result_o(result_o), .wr_en_o(wr_en_o), .skip_o(skip_o),
        .ovf_next_o(ovf_next_o), .ovf_o(ovf_o)
    );

    task automatic check(input string tag, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Present one instruction, check the same-cycle outputs, then the overflow word after the edge.
    task automatic apply(input string tag, input logic v, input logic [3:0] op,
                         input logic dst, input logic [15:0] a, input logic [15:0] b,
                         input logic chk_res, input logic [15:0] e_res,
                         input logic e_wr, input logic e_skip, input logic [15:0] e_ovf);
        @(negedge clk);
        valid_i = v; opcode_i = op; dst_ovf_i = dst; opa_i = a; opb_i = b;
        #1;
        if (chk_res) check(tag, "result", result_o, e_res);
        check(tag, "wr_en", {15'b0, wr_en_o}, {15'b0, e_wr});
        check(tag, "skip", {15'b0, skip_o}, {15'b0, e_skip});
        @(posedge clk);
        #1;
        check(tag, "ovf", ovf_o, e_ovf);
        valid_i = 1'b0;
    endtask

    task automatic preload(input logic [15:0] val);
        apply("R12", 1'b1, 4'h1, 1'b1, 16'h0000, val, 1'b1, val, 1'b1, 1'b0, val);
    endtask

    task automatic t_reset;
        #1;
        check("R1", "ovf in reset", ovf_o, 16'h0000);
        repeat (2) @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check("R1", "ovf after reset", ovf_o, 16'h0000);
    endtask

    task automatic t_set;
        preload(16'h1357);
        apply("R2", 1'b1, 4'h1, 1'b0, 16'h1234, 16'hBEEF, 1'b1, 16'hBEEF, 1'b1, 1'b0, 16'h1357);
    endtask

    task automatic t_add_sub;
        apply("R3", 1'b1, 4'h2, 1'b0, 16'hFFFF, 16'h0002, 1'b1, 16'h0001, 1'b1, 1'b0, 16'h0001);
        apply("R3", 1'b1, 4'h2, 1'b0, 16'h0010, 16'h0020, 1'b1, 16'h0030, 1'b1, 1'b0, 16'h0000);
        apply("R4", 1'b1, 4'h3, 1'b0, 16'h0005, 16'h0007, 1'b1, 16'hFFFE, 1'b1, 1'b0, 16'hFFFF);
        apply("R4", 1'b1, 4'h3, 1'b0, 16'h0007, 16'h0005, 1'b1, 16'h0002, 1'b1, 1'b0, 16'h0000);
    endtask

    task automatic t_mul;
        apply("R5", 1'b1, 4'h4, 1'b0, 16'h1234, 16'h0100, 1'b1, 16'h3400, 1'b1, 1'b0, 16'h0012);
        apply("R5", 1'b1, 4'h4, 1'b0, 16'hFFFF, 16'hFFFF, 1'b1, 16'h0001, 1'b1, 1'b0, 16'hFFFE);
    endtask

    task automatic t_div_mod;
        apply("R6", 1'b1, 4'h5, 1'b0, 16'h0017, 16'h0042, 1'b1, 16'h0000, 1'b1, 1'b0, 16'h5936);
        apply("R6", 1'b1, 4'h5, 1'b0, 16'h0064, 16'h0007, 1'b1, 16'h000E, 1'b1, 1'b0, 16'h4924);
        apply("R6", 1'b1, 4'h5, 1'b0, 16'h1234, 16'h0000, 1'b1, 16'h0000, 1'b1, 1'b0, 16'h0000);
        preload(16'h5555);
        apply("R7", 1'b1, 4'h6, 1'b0, 16'h0064, 16'h0007, 1'b1, 16'h0002, 1'b1, 1'b0, 16'h5555);
        apply("R7", 1'b1, 4'h6, 1'b0, 16'h0064, 16'h0000, 1'b1, 16'h0000, 1'b1, 1'b0, 16'h5555);
    endtask

    task automatic t_shift;
        apply("R8", 1'b1, 4'h7, 1'b0, 16'h8421, 16'd4,  1'b1, 16'h4210, 1'b1, 1'b0, 16'h0008);
        apply("R8", 1'b1, 4'h7, 1'b0, 16'h0001, 16'd20, 1'b1, 16'h0000, 1'b1, 1'b0, 16'h0010);
        apply("R8", 1'b1, 4'h7, 1'b0, 16'hFFFF, 16'd40, 1'b1, 16'h0000, 1'b1, 1'b0, 16'h0000);
        apply("R8", 1'b1, 4'h8, 1'b0, 16'h8421, 16'd4,  1'b1, 16'h0842, 1'b1, 1'b0, 16'h1000);
        apply("R8", 1'b1, 4'h8, 1'b0, 16'h8421, 16'd0,  1'b1, 16'h8421, 1'b1, 1'b0, 16'h0000);
    endtask

    task automatic t_logic;
        preload(16'h5555);
        apply("R9", 1'b1, 4'h9, 1'b0, 16'hF0F0, 16'h0FFF, 1'b1, 16'h00F0, 1'b1, 1'b0, 16'h5555);
        apply("R9", 1'b1, 4'hA, 1'b0, 16'hF0F0, 16'h0F0F, 1'b1, 16'hFFFF, 1'b1, 1'b0, 16'h5555);
        apply("R9", 1'b1, 4'hB, 1'b0, 16'hF0F0, 16'hFF00, 1'b1, 16'h0FF0, 1'b1, 1'b0, 16'h5555);
    endtask

    task automatic t_tests;
        preload(16'hA5A5);
        apply("R10", 1'b1, 4'hC, 1'b0, 16'h0042, 16'h0042, 1'b0, 16'h0, 1'b0, 1'b0, 16'hA5A5);
        apply("R10", 1'b1, 4'hC, 1'b0, 16'h0017, 16'h0042, 1'b0, 16'h0, 1'b0, 1'b1, 16'hA5A5);
        apply("R10", 1'b1, 4'hD, 1'b0, 16'h0042, 16'h0042, 1'b0, 16'h0, 1'b0, 1'b1, 16'hA5A5);
        apply("R10", 1'b1, 4'hD, 1'b0, 16'h0017, 16'h0042, 1'b0, 16'h0, 1'b0, 1'b0, 16'hA5A5);
        apply("R10", 1'b1, 4'hE, 1'b0, 16'h0041, 16'h0042, 1'b0, 16'h0, 1'b0, 1'b1, 16'hA5A5);
        apply("R10", 1'b1, 4'hE, 1'b0, 16'h0042, 16'h0042, 1'b0, 16'h0, 1'b0, 1'b1, 16'hA5A5);
        apply("R10", 1'b1, 4'hE, 1'b0, 16'h0042, 16'h0041, 1'b0, 16'h0, 1'b0, 1'b0, 16'hA5A5);
        apply("R10", 1'b1, 4'hE, 1'b0, 16'h8000, 16'h7FFF, 1'b0, 16'h0, 1'b0, 1'b0, 16'hA5A5);
        apply("R10", 1'b1, 4'hF, 1'b0, 16'hF0F0, 16'h0F0F, 1'b0, 16'h0, 1'b0, 1'b1, 16'hA5A5);
        apply("R10", 1'b1, 4'hF, 1'b0, 16'hF1F0, 16'h0F0F, 1'b0, 16'h0, 1'b0, 1'b0, 16'hA5A5);
        apply("R10", 1'b1, 4'hC, 1'b1, 16'h1111, 16'h1111, 1'b0, 16'h0, 1'b0, 1'b0, 16'hA5A5);
    endtask

    task automatic t_idle;
        apply("R11", 1'b1, 4'h0, 1'b0, 16'hFFFF, 16'h0001, 1'b0, 16'h0, 1'b0, 1'b0, 16'hA5A5);
        apply("R11", 1'b0, 4'h2, 1'b0, 16'hFFFF, 16'h0001, 1'b0, 16'h0, 1'b0, 1'b0, 16'hA5A5);
        apply("R11", 1'b0, 4'hC, 1'b1, 16'h0001, 16'h0002, 1'b0, 16'h0, 1'b0, 1'b0, 16'hA5A5);
    endtask

    task automatic t_dst_ovf;
        preload(16'h5555);
        apply("R12", 1'b1, 4'h2, 1'b1, 16'hFFFF, 16'h0001, 1'b1, 16'h0000, 1'b1, 1'b0, 16'h0000);
        apply("R12", 1'b1, 4'h4, 1'b1, 16'h0003, 16'h0005, 1'b1, 16'h000F, 1'b1, 1'b0, 16'h000F);
    endtask

    initial begin
        t_reset();
        t_set();
        t_add_sub();
        t_mul();
        t_div_mod();
        t_shift();
        t_logic();
        t_tests();
        t_idle();
        t_dst_ovf();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule